// File: doc/BRIEF.md
# Multi-Waveform Phase-Accumulator Oscillator

This block is a digital tone source built around a phase accumulator. On every clock it adds a frequency word to a 24-bit phase register, and from the top of that register it derives four 12-bit waveforms: a rising ramp, a symmetric triangle, a variable-width pulse and a pseudo-random noise sequence. A four-bit select input chooses which waveforms reach the output. When several are chosen at once, they are combined bit by bit with a logical AND, which gives the harsh hybrid timbres of classic sound generators.

A 23-bit linear feedback shift register makes the noise. It advances only when a chosen accumulator bit rises, so the noise pitch follows the frequency word. The register takes its feedback from the combined output word and not from itself. When noise is selected together with another waveform, the ANDed bits can therefore drain the register to all zeros, and the noise source then stays silent. A test input holds the phase at zero and reloads the noise register with a fixed nonzero seed. This is the only way to recover from that state.

Top module: `multi_wave_osc`

## Requirements
- R1: While reset is high and on the first cycle after it, the accumulator is zero and the noise register holds the seed 0x5A5A5A, so a ramp-only selection outputs 0.
- R2: Each clock with test low, the accumulator advances by the frequency word modulo 2^24. The ramp waveform (select bit 1) is accumulator bits [23:12].
- R3: The triangle waveform (select bit 0) is accumulator bits [22:11], with every bit inverted while accumulator bit 23 is 1.
- R4: The pulse waveform (select bit 2) is 0xFFF when accumulator bits [23:12] are greater than or equal to the pulse-width input, and 0x000 otherwise.
- R5: With select equal to 0 the output is 0.
- R6: With two or more select bits set, the output is the bitwise AND of the selected waveforms.
- R7: The noise waveform (select bit 3) is noise register bits [22:11]. The register shifts left by one on each cycle that follows a 0-to-1 change of accumulator bit 19, and the new bit 0 is the XOR of bits 22 and 17.
- R8: While noise is selected, the feedback bit is the XOR of output bits 11 and 6 after the AND. A combined selection can fill the register with zeros, after which noise alone stays at 0.
- R9: While test is high, the accumulator is held at zero and the noise register is reloaded with 0x5A5A5A, so noise alone outputs 0xB4B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_word | input | 16 | Phase increment per clock |
| pulse_width | input | 12 | Pulse threshold compared with the phase |
| wave_sel | input | 4 | Bit 0 triangle, bit 1 ramp, bit 2 pulse, bit 3 noise |
| test_hold | input | 1 | Holds phase at zero and reseeds noise |
| wave_out | output | 12 | Combined waveform sample |

## Verification
The embedded assertions check on every cycle that the phase steps by exactly the frequency word, that test forces zero phase and the seed value, and that the noise register holds still between clock events. They also check that the pulse is always all-ones or all-zeros and that an empty selection gives silence. Only the bench scenarios can show the waveform shapes over many cycles, the AND combination of mixed selections, and the gradual drain of the noise register into its locked all-zero state followed by recovery through test.

// File: rtl/osc_pkg.sv
package osc_pkg;
    localparam int ACC_W    = 24;
    localparam int FREQ_W   = 16;
    localparam int OUT_W    = 12;
    localparam int LFSR_W   = 23;
    localparam int STEP_BIT = 19;
    localparam int TAP_HI   = 22;
    localparam int TAP_LO   = 17;
    localparam logic [LFSR_W-1:0] NOISE_SEED = 23'h5A5A5A;

    localparam int NOISE_LSB  = LFSR_W - OUT_W;
    localparam int OUT_TAP_HI = TAP_HI - NOISE_LSB;
    localparam int OUT_TAP_LO = TAP_LO - NOISE_LSB;
    localparam int N_WAVES    = 4;

    typedef logic [OUT_W-1:0] sample_t;

    typedef struct packed {
        logic noise;
        logic pulse;
        logic ramp;
        logic tri_en;
    } wave_sel_t;

    typedef struct packed {
        sample_t noise;
        sample_t pulse;
        sample_t ramp;
        sample_t tri_w;
    } wave_set_t;

    function automatic sample_t fold_triangle(input logic [ACC_W-1:0] ph);
        sample_t t;
        t = ph[ACC_W-2 -: OUT_W];
        return ph[ACC_W-1] ? ~t : t;
    endfunction
endpackage

// File: rtl/osc_phase_accum.sv
module osc_phase_accum
    import osc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [FREQ_W-1:0] incr,
    output logic [ACC_W-1:0]  phase
);
    always_ff @(posedge clk) begin
        if (rst || hold) phase <= '0;
        else             phase <= phase + ACC_W'(incr);
    end

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        !hold |=> phase == $past(phase) + ACC_W'($past(incr)));
    assert_hold_zero_R9: assert property (@(posedge clk) disable iff (rst)
        hold |=> phase == '0);
endmodule

// File: rtl/osc_noise_lfsr.sv
module osc_noise_lfsr
    import osc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reload,
    input  logic              clk_bit,
    input  logic              fb_bit,
    output logic [LFSR_W-1:0] state
);
    logic prev_bit;
    logic step;

    assign step = clk_bit & ~prev_bit;

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            state    <= NOISE_SEED;
            prev_bit <= 1'b0;
        end else begin
            prev_bit <= clk_bit;
            if (step) state <= {state[LFSR_W-2:0], fb_bit};
        end
    end

    assert_lfsr_still_R7: assert property (@(posedge clk) disable iff (rst)
        (!step && !reload) |=> $stable(state));
    assert_lfsr_seed_R9: assert property (@(posedge clk) disable iff (rst)
        reload |=> state == NOISE_SEED);
endmodule

// File: rtl/osc_wave_shaper.sv
module osc_wave_shaper
    import osc_pkg::*;
(
    input  logic [ACC_W-1:0]  phase,
    input  logic [LFSR_W-1:0] noise_state,
    input  sample_t           width,
    input  wave_sel_t         sel,
    output sample_t           mixed
);
    wave_set_t waves;
    sample_t   ramp_v;
    logic [N_WAVES-1:0] sel_bits;
    sample_t   stage [N_WAVES+1];

    assign ramp_v      = phase[ACC_W-1 -: OUT_W];
    assign waves.ramp  = ramp_v;
    assign waves.tri_w = fold_triangle(phase);
    assign waves.pulse = (ramp_v >= width) ? '1 : '0;
    assign waves.noise = noise_state[LFSR_W-1 -: OUT_W];
    assign sel_bits    = sel;

    assign stage[0] = '1;
    for (genvar i = 0; i < N_WAVES; i++) begin : g_and
        sample_t src;
        assign src = waves[i*OUT_W +: OUT_W];
        assign stage[i+1] = sel_bits[i] ? (stage[i] & src) : stage[i];
    end

    assign mixed = (sel_bits == '0) ? '0 : stage[N_WAVES];

    always_comb begin
        assert_pulse_level_R4: assert (waves.pulse == '0 || waves.pulse == '1);
    end
endmodule

// File: rtl/multi_wave_osc.sv
module multi_wave_osc
    import osc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] freq_word,
    input  logic [11:0] pulse_width,
    input  logic [3:0]  wave_sel,
    input  logic        test_hold,
    output logic [11:0] wave_out
);
    logic [ACC_W-1:0]  phase;
    logic [LFSR_W-1:0] noise_state;
    wave_sel_t         sel;
    sample_t           mixed;
    logic              fb_bit;

    assign sel = wave_sel_t'(wave_sel);

    osc_phase_accum u_acc (
        .clk(clk), .rst(rst), .hold(test_hold),
        .incr(freq_word), .phase(phase)
    );

    assign fb_bit = sel.noise ? (mixed[OUT_TAP_HI] ^ mixed[OUT_TAP_LO])
                              : (noise_state[TAP_HI] ^ noise_state[TAP_LO]);

    osc_noise_lfsr u_lfsr (
        .clk(clk), .rst(rst), .reload(test_hold),
        .clk_bit(phase[STEP_BIT]), .fb_bit(fb_bit), .state(noise_state)
    );

    osc_wave_shaper u_shape (
        .phase(phase), .noise_state(noise_state), .width(pulse_width),
        .sel(sel), .mixed(mixed)
    );

    assign wave_out = mixed;

    assert_silent_none_R5: assert property (@(posedge clk) disable iff (rst)
        wave_sel == 4'd0 |-> wave_out == 12'd0);
    assert_ramp_after_reset_R1: assert property (@(posedge clk)
        rst |=> (wave_sel != 4'b0010 || wave_out == 12'd0));
endmodule

// File: tb/multi_wave_osc_test.sv
module multi_wave_osc_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] freq_word = '0;
    logic [11:0] pulse_width = '0;
    logic [3:0]  wave_sel = 4'b0010;
    logic        test_hold = 1'b0;
    logic [11:0] wave_out;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    logic done = 1'b0;

    int unsigned m_acc = 0;
    int unsigned m_lfsr = 32'h5A5A5A;
    bit m_prev = 0;

    multi_wave_osc uut (
        .clk(clk), .rst(rst), .freq_word(freq_word), .pulse_width(pulse_width),
        .wave_sel(wave_sel), .test_hold(test_hold), .wave_out(wave_out)
    );

    always #2.5 clk = ~clk;

    function automatic int unsigned model_out(int unsigned acc, int unsigned lf,
                                              logic [3:0] s, logic [11:0] pw);
        int unsigned saw, tri_v, pul, noi, r;
        saw   = (acc >> 12) & 12'hFFF;
        tri_v = (acc >> 11) & 12'hFFF;
        if ((acc >> 23) & 1) tri_v = (~tri_v) & 12'hFFF;
        pul   = (saw >= pw) ? 12'hFFF : 0;
        noi   = (lf >> 11) & 12'hFFF;
        if (s == 0) return 0;
        r = 12'hFFF;
        if (s[0]) r &= tri_v;
        if (s[1]) r &= saw;
        if (s[2]) r &= pul;
        if (s[3]) r &= noi;
        return r;
    endfunction

    always @(posedge clk) begin
        int unsigned o;
        bit fb, b19;
        if (rst || test_hold) begin
            m_acc = 0; m_prev = 0; m_lfsr = 32'h5A5A5A;
        end else begin
            o   = model_out(m_acc, m_lfsr, wave_sel, pulse_width);
            b19 = (m_acc >> 19) & 1;
            if (b19 && !m_prev) begin
                if (wave_sel[3]) fb = ((o >> 11) ^ (o >> 6)) & 1;
                else             fb = ((m_lfsr >> 22) ^ (m_lfsr >> 17)) & 1;
                m_lfsr = ((m_lfsr << 1) | fb) & 32'h7FFFFF;
            end
            m_prev = b19;
            m_acc  = (m_acc + freq_word) & 32'hFFFFFF;
        end
    end

    task automatic check(string req, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%03h expected=%03h t=%0t", req, act, exp, $time);
        end
    endtask

    // continuous comparison against the reference model
    always @(negedge clk) begin
        if (!rst && !done)
            check(cur_req, wave_out, model_out(m_acc, m_lfsr, wave_sel, pulse_width));
    end

    task automatic run(string req, int n, logic [15:0] f, logic [11:0] pw, logic [3:0] s);
        @(posedge clk); #1;
        cur_req = req; freq_word = f; pulse_width = pw; wave_sel = s;
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1", wave_out, 12'h000);           // R1: reset state
        run("R2", 3000, 16'h1234, 12'h000, 4'b0010); // R2 ramp
        run("R3", 3000, 16'h2345, 12'h000, 4'b0001); // R3 triangle
        run("R4", 2000, 16'h3001, 12'h800, 4'b0100); // R4 pulse
        run("R4", 2000, 16'h0F0F, 12'hFFF, 4'b0100); // R4 boundary
        run("R5", 500,  16'h4444, 12'h100, 4'b0000); // R5 silent
        @(negedge clk); check("R5", wave_out, 12'h000);
        run("R6", 2000, 16'h1357, 12'h400, 4'b0011); // R6 tri AND ramp
        run("R6", 2000, 16'h2468, 12'h600, 4'b0110); // R6 ramp AND pulse
        run("R7", 3000, 16'hF000, 12'h000, 4'b1000); // R7 noise alone
        // R9: test reseeds and holds phase
        @(posedge clk); #1 test_hold = 1'b1; cur_req = "R9";
        repeat (4) @(posedge clk);
        @(negedge clk); check("R9", wave_out, 12'hB4B);
        @(posedge clk); #1 test_hold = 1'b0;
        // R8: combined selection drains the noise register
        run("R8", 3000, 16'hFFFF, 12'hFFF, 4'b1100);
        run("R8", 1500, 16'hFFFF, 12'h000, 4'b1000);
        @(negedge clk); check("R8", wave_out, 12'h000);
        @(posedge clk); #1 test_hold = 1'b1; cur_req = "R9";
        repeat (2) @(posedge clk);
        @(posedge clk); #1 test_hold = 1'b0;
        run("R9", 1500, 16'hF000, 12'h000, 4'b1000);
        // R1: reset mid-run
        @(posedge clk); #1 rst = 1'b1; wave_sel = 4'b0010; cur_req = "R1";
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); check("R1", wave_out, 12'h000);
        run("R1", 200, 16'h0800, 12'h000, 4'b0010);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule